// File: doc/BRIEF.md
# Fixed-Period Current Chopping Controller

This block drives the four gates of one H-bridge winding with fixed-period PWM current chopping. A period counter, clocked by the system clock, opens each period by driving the bridge in the direction requested at that moment. A current comparator then ends the on-time. Trips that arrive during a blanking window at the start of the period are ignored, so that window also acts as the minimum on-time. After a trip, the bridge stays in a decay state until the next period begins.

There are three decay styles. Slow decay turns on both low-side switches. Fast decay reverses the bridge and then turns all gates off once a zero-current detector fires. Mixed decay starts as fast decay and changes to slow decay at three quarters of the period, but only when the current target is falling; a rising target gets slow decay. The decay style comes from a three-level pin, which reaches the block as two window-comparator bits. Every change of a leg between its high-side and low-side switch passes through at least one clock with both switches off. Deasserting enable turns all gates off at once.

Top module: `chop_ctrl`

## Requirements
- R1: A PWM period lasts PERIOD_CYC clocks. The period counter starts at 0 on the first clock edge with enable high and wraps after PERIOD_CYC-1. A decision taken at an edge shows on the gates one edge later, so the bridge first drives after the second edge.
- R2: At the start of each period the block latches dir_pos. High drives hs1 and ls2; low drives ls1 and hs2. A change of dir_pos inside a period has no effect until the next period starts.
- R3: A trip is accepted only at an edge where the period count is BLANK_CYC or more. Trips at earlier counts are ignored.
- R4: After an accepted trip, the bridge stays in decay for the rest of the period.
- R5: Slow decay turns on ls1 and ls2 only.
- R6: Fast decay reverses the drive pattern. Once zero_det is seen during fast decay, all four gates stay off until the next period.
- R7: In mixed decay with tgt_falling latched high, the block uses fast decay until the count reaches (PERIOD_CYC*3)/4, then slow decay. This includes the case where zero_det has already turned the gates off. A trip accepted at or after that count goes straight to slow decay.
- R8: In mixed decay with tgt_falling latched low, the block uses slow decay.
- R9: The decay style is decoded from {decay_hi, decay_lo} at the trip: 00 selects slow, 11 selects fast, and 01 or 10 (pin left open) selects mixed.
- R10: When a leg changes between its high-side and low-side switch, both switches of that leg are off for at least one clock in between. A switch is never on in the clock right after its partner on the same leg.
- R11: While enable is low, all gates are off in the same cycle. The counter restarts from 0 when enable returns.
- R12: While rst_n is low (asynchronous), all gates are off and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the chopper; low turns all gates off |
| dir_pos | input | 1 | Sign of the requested winding current (1 = positive) |
| tgt_falling | input | 1 | Target current magnitude is decreasing |
| trip | input | 1 | Current comparator above threshold |
| zero_det | input | 1 | Winding current near zero |
| decay_hi | input | 1 | Decay pin sensed above upper threshold |
| decay_lo | input | 1 | Decay pin sensed above lower threshold |
| hs1 | output | 1 | Leg 1 high-side gate enable |
| ls1 | output | 1 | Leg 1 low-side gate enable |
| hs2 | output | 1 | Leg 2 high-side gate enable |
| ls2 | output | 1 | Leg 2 low-side gate enable |

## Verification
The assertions assume that enable, trip, zero_det and the decay bits are synchronous to clk and settle between edges. They also assume the parameters place the blanking count below the three-quarter point. The stimulus changes every input only on the falling clock edge. It keeps trip and zero_det as levels that stay asserted once raised within a run. It uses a short period (40 clocks, blanking 8), so the mixed-decay switch point at count 30 lies well past blanking.

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int PERIOD_CYC = 2500,
  parameter int BLANK_CYC  = 938
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic dir_pos,
  input  logic tgt_falling,
  input  logic trip,
  input  logic zero_det,
  input  logic decay_hi,
  input  logic decay_lo,
  output logic hs1,
  output logic ls1,
  output logic hs2,
  output logic ls2
);
  localparam int CW = $clog2(PERIOD_CYC);
  localparam logic [CW-1:0] LAST_V  = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] BLANK_V = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MIX_V   = CW'((PERIOD_CYC * 3) / 4);

  typedef enum logic [2:0] {PH_IDLE, PH_DRIVE, PH_FAST, PH_SLOW, PH_COAST} phase_t;
  typedef enum logic [1:0] {L_OFF, L_HI, L_LO} leg_t;

  logic [CW-1:0] cnt;
  phase_t phase;
  logic dir_q, fall_q, mix_q;
  leg_t leg1, leg2, want1, want2;

  wire sel_fast = decay_hi & decay_lo;
  wire sel_slow = ~decay_hi & ~decay_lo;
  wire sel_mix  = ~(sel_fast | sel_slow);
  wire past_blank = cnt >= BLANK_V;
  wire late       = cnt >= MIX_V;

  // a leg may only leave OFF or return to OFF; HI<->LO goes through OFF
  function automatic leg_t step(input leg_t cur, input leg_t want);
    if (cur == L_OFF) return want;
    if (cur == want)  return cur;
    return L_OFF;
  endfunction

  always_comb begin
    want1 = L_OFF;
    want2 = L_OFF;
    case (phase)
      PH_DRIVE: begin
        want1 = dir_q ? L_HI : L_LO;
        want2 = dir_q ? L_LO : L_HI;
      end
      PH_FAST: begin
        want1 = dir_q ? L_LO : L_HI;
        want2 = dir_q ? L_HI : L_LO;
      end
      PH_SLOW: begin
        want1 = L_LO;
        want2 = L_LO;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      phase  <= PH_IDLE;
      dir_q  <= 1'b0;
      fall_q <= 1'b0;
      mix_q  <= 1'b0;
      leg1   <= L_OFF;
      leg2   <= L_OFF;
    end else if (!enable) begin
      cnt    <= '0;
      phase  <= PH_IDLE;
      mix_q  <= 1'b0;
      leg1   <= L_OFF;
      leg2   <= L_OFF;
    end else begin
      cnt  <= (cnt == LAST_V) ? '0 : cnt + 1'b1;
      leg1 <= step(leg1, want1);
      leg2 <= step(leg2, want2);
      if (cnt == '0) begin
        phase  <= PH_DRIVE;
        dir_q  <= dir_pos;
        fall_q <= tgt_falling;
        mix_q  <= 1'b0;
      end else begin
        case (phase)
          PH_DRIVE:
            if (trip && past_blank) begin
              mix_q <= sel_mix & fall_q;
              if (sel_fast || (sel_mix && fall_q && !late)) phase <= PH_FAST;
              else                                         phase <= PH_SLOW;
            end
          PH_FAST:
            if (mix_q && late)  phase <= PH_SLOW;
            else if (zero_det)  phase <= PH_COAST;
          PH_COAST:
            if (mix_q && late)  phase <= PH_SLOW;
          default: ;
        endcase
      end
    end
  end

  assign hs1 = enable && (leg1 == L_HI);
  assign ls1 = enable && (leg1 == L_LO);
  assign hs2 = enable && (leg2 == L_HI);
  assign ls2 = enable && (leg2 == L_LO);

  a_r10_leg1_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n) ls1 |=> !hs1);
  a_r10_leg1_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n) hs1 |=> !ls1);
  a_r10_leg2_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n) ls2 |=> !hs2);
  a_r10_leg2_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n) hs2 |=> !ls2);

  a_r1_period_opens: assert property (@(posedge clk) disable iff (!rst_n)
    enable && cnt == '0 |=> phase == PH_DRIVE);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    enable && cnt == LAST_V |=> cnt == '0);
  a_r3_blanking: assert property (@(posedge clk) disable iff (!rst_n)
    enable && phase == PH_DRIVE && cnt < BLANK_V |=> phase == PH_DRIVE);
  a_r4_slow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    enable && phase == PH_SLOW && cnt != '0 |=> phase == PH_SLOW);
  a_r7_no_fast_late: assert property (@(posedge clk) disable iff (!rst_n)
    enable && mix_q && cnt > MIX_V |-> phase != PH_FAST);
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt == '0 && phase == PH_IDLE);
endmodule

// File: tb/test_chop_ctrl.sv
`timescale 1ns/1ps
module test_chop_ctrl;
  logic clk = 1'b0;
  logic rst_n, enable, dir_pos, tgt_falling, trip, zero_det, decay_hi, decay_lo;
  logic hs1, ls1, hs2, ls2;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chop_ctrl #(.PERIOD_CYC(40), .BLANK_CYC(8)) i_chop_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir_pos(dir_pos),
    .tgt_falling(tgt_falling), .trip(trip), .zero_det(zero_det),
    .decay_hi(decay_hi), .decay_lo(decay_lo),
    .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2));

  // {dir, falling, {decay_hi,decay_lo}, trip_t, zero_t, probe_t, gates {hs1,ls1,hs2,ls2}, req}
  localparam int NV = 22;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b00, 8'd255, 8'd255, 8'd5,  4'b1001, 4'd2},  // R2 positive drive
    {1'b0, 1'b0, 2'b00, 8'd255, 8'd255, 8'd5,  4'b0110, 4'd2},  // R2 negative drive
    {1'b1, 1'b0, 2'b00, 8'd0,   8'd255, 8'd1,  4'b0000, 4'd1},  // R1 gates still off after first edge
    {1'b1, 1'b0, 2'b00, 8'd0,   8'd255, 8'd9,  4'b1001, 4'd3},  // R3 trip held during blanking
    {1'b1, 1'b0, 2'b00, 8'd0,   8'd255, 8'd10, 4'b0001, 4'd10}, // R10 leg1 dead clock into slow
    {1'b1, 1'b0, 2'b00, 8'd0,   8'd255, 8'd11, 4'b0101, 4'd5},  // R5 slow decay
    {1'b1, 1'b0, 2'b00, 8'd0,   8'd255, 8'd39, 4'b0101, 4'd4},  // R4 decay held to period end
    {1'b1, 1'b1, 2'b11, 8'd12,  8'd255, 8'd14, 4'b0000, 4'd10}, // R10 both legs dead
    {1'b1, 1'b1, 2'b11, 8'd12,  8'd255, 8'd15, 4'b0110, 4'd6},  // R6 fast reverses
    {1'b0, 1'b1, 2'b11, 8'd12,  8'd255, 8'd15, 4'b1001, 4'd6},  // R6 fast reverses, negative
    {1'b1, 1'b1, 2'b11, 8'd12,  8'd20,  8'd21, 4'b0110, 4'd6},  // R6 before zero seen
    {1'b1, 1'b1, 2'b11, 8'd12,  8'd20,  8'd22, 4'b0000, 4'd6},  // R6 off after zero
    {1'b1, 1'b1, 2'b01, 8'd12,  8'd255, 8'd31, 4'b0110, 4'd7},  // R7 still fast at switch edge
    {1'b1, 1'b1, 2'b01, 8'd12,  8'd255, 8'd32, 4'b0100, 4'd7},  // R7 dead clock into slow
    {1'b1, 1'b1, 2'b01, 8'd12,  8'd255, 8'd33, 4'b0101, 4'd7},  // R7 slow after 75%
    {1'b1, 1'b0, 2'b01, 8'd12,  8'd255, 8'd15, 4'b0101, 4'd8},  // R8 mixed with rising target
    {1'b1, 1'b1, 2'b10, 8'd12,  8'd255, 8'd15, 4'b0110, 4'd9},  // R9 code 10 decodes as mixed
    {1'b1, 1'b1, 2'b01, 8'd12,  8'd20,  8'd32, 4'b0101, 4'd7},  // R7 coast then slow
    {1'b1, 1'b0, 2'b00, 8'd12,  8'd255, 8'd42, 4'b0001, 4'd1},  // R1 next period, dead clock
    {1'b1, 1'b0, 2'b00, 8'd12,  8'd255, 8'd43, 4'b1001, 4'd1},  // R1 next period drives
    {1'b1, 1'b0, 2'b00, 8'd12,  8'd255, 8'd48, 4'b1001, 4'd3},  // R3 blanking in second period
    {1'b1, 1'b1, 2'b01, 8'd32,  8'd255, 8'd35, 4'b0101, 4'd7}   // R7 late trip goes straight slow
  };

  task automatic check(input logic [3:0] exp, input int req, input string what);
    logic [3:0] got;
    got = {hs1, ls1, hs2, ls2};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: gates %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic stim(input int t, input logic d, input int trip_t, zero_t, flip_t);
    trip     = (t >= trip_t);
    zero_det = (t >= zero_t);
    dir_pos  = (t >= flip_t) ? ~d : d;
  endtask

  task automatic run(input logic d, f, input logic [1:0] sel, input int trip_t, zero_t,
                     flip_t, probe_t, input logic [3:0] exp, input int req, input string what);
    enable = 1'b0; trip = 1'b0; zero_det = 1'b0;
    dir_pos = d; tgt_falling = f; {decay_hi, decay_lo} = sel;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    stim(0, d, trip_t, zero_t, flip_t);
    for (int t = 1; t <= probe_t; t++) begin
      @(negedge clk);
      if (t < probe_t) stim(t, d, trip_t, zero_t, flip_t);
    end
    check(exp, req, what);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; dir_pos = 1'b1; tgt_falling = 1'b0;
    trip = 1'b0; zero_det = 1'b0; decay_hi = 1'b0; decay_lo = 1'b0;
    repeat (3) @(negedge clk);
    check(4'b0000, 12, "reset with enable high");  // R12
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      run(v[35], v[34], v[33:32], int'(v[31:24]), int'(v[23:16]), 255,
          int'(v[15:8]), v[7:4], int'(v[3:0]), $sformatf("row %0d", i));
    end

    // R11: enable low turns gates off within the cycle, counter restarts
    run(1'b1, 1'b0, 2'b00, 255, 255, 255, 5, 4'b1001, 2, "drive before disable");
    enable = 1'b0;
    #1 check(4'b0000, 11, "gates off same cycle");
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(4'b0000, 11, "first edge after re-enable");
    @(negedge clk);
    check(4'b1001, 11, "drive at second edge after re-enable");

    // R2: direction change inside a period waits for the next period
    run(1'b1, 1'b0, 2'b00, 255, 255, 5, 20, 4'b1001, 2, "mid-period dir change ignored");
    run(1'b1, 1'b0, 2'b00, 255, 255, 5, 42, 4'b0000, 10, "dead clock on direction swap");
    run(1'b1, 1'b0, 2'b00, 255, 255, 5, 43, 4'b0110, 2, "new direction next period");

    // R12: asynchronous reset while driving
    run(1'b1, 1'b0, 2'b00, 255, 255, 255, 5, 4'b1001, 2, "drive before reset");
    rst_n = 1'b0;
    #1 check(4'b0000, 12, "async reset clears gates");
    @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule